// File: doc/BRIEF.md
# Dual Time-of-Day Alarm Unit

This block keeps two alarms and compares them with the live time of day. A time counter outside the block supplies the current minutes, hours and weekday, along with a one-cycle strobe that marks the start of each new minute (seconds rolling to 00). The weekday alarm holds a minute, an hour and a seven-bit mask of weekdays. It fires when minute and hour agree and the mask bit for the current weekday is set, so any mix of days can be chosen. The daily alarm holds only a minute and an hour and takes no account of the weekday.

Each alarm has an enable bit and a sticky flag. A flag drives the active-low interrupt output only while its enable bit is set. Host logic reaches every alarm field, both enables and both flags through a small synchronous register port with a combinational read path. A two-state evaluation machine handles the matching. In state `EV_IDLE` it waits for the minute strobe. Transition *capture*: on the strobe it stores the time and enters `EV_COMPARE`. In `EV_COMPARE` it sets the flag of each enabled alarm whose comparison holds. Transition *release*: it then returns to `EV_IDLE`. Transition *recapture*: if a new strobe arrives while in `EV_COMPARE`, it stores the new time and stays in `EV_COMPARE`.

Top module: `alarm_pair_unit`

## Requirements
- R1: After reset, all alarm fields, both enables and both flags read as 0, and `irq_n` is 1.
- R2: A write takes effect at the clock edge where `reg_wr` is 1. The read data follows `reg_addr` combinationally. The register map is: 0 weekday-alarm minute (7 bits), 1 weekday-alarm hour (6 bits), 2 weekday mask (7 bits), 3 daily-alarm minute (7 bits), 4 daily-alarm hour (6 bits), 5 enables (bit0 weekday, bit1 daily), 6 flags (bit0 weekday, bit1 daily). Address 7 and all bits above each field read as 0.
- R3: The weekday alarm matches when the BCD minute (tens in bits 6..4, units in bits 3..0) equals the captured minute, all six hour bits are equal (bit 5 is the 20-hours / PM bit), and mask bit `wday` is 1. A weekday code of 7 never matches.
- R4: Matching uses only the time captured at a minute strobe. A flag is set at the second clock edge after the strobe is sampled, and a time that matches without a strobe sets nothing.
- R5: The daily alarm matches on minute and hour alone, whatever the weekday code.
- R6: A flag is set on a match only when its enable bit is 1 at the comparison edge. Once set, a flag stays set until it is cleared.
- R7: Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R8: `irq_n` is 0 exactly while (weekday flag AND weekday enable) OR (daily flag AND daily enable). Clearing an enable bit removes that alarm's contribution from the edge of the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| minute_tick | input | 1 | One-cycle strobe at each new minute |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, same layout as the alarm hour fields |
| cur_wday | input | 3 | Current weekday code, 0 to 6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
Register writes are visible in `reg_rdata` in the cycle after the write edge, and reads are valid in the same cycle as the address. A flag, and with it `irq_n`, changes after the second rising edge that follows the cycle in which `minute_tick` is high. Clearing an enable releases `irq_n` right after the write edge. The bench drives inputs on falling edges and samples 2 ns later, with a behavioural model updated on each rising edge. The model's pending-strobe variable adds exactly one stage of delay, so every comparison lands in the cycle the requirements name.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DAY_N  = 7;
    localparam int WDAY_W = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_WK_MIN  = 3'd0,
        RA_WK_HOUR = 3'd1,
        RA_WK_DAYS = 3'd2,
        RA_DL_MIN  = 3'd3,
        RA_DL_HOUR = 3'd4,
        RA_ENABLE  = 3'd5,
        RA_STATUS  = 3'd6,
        RA_NONE    = 3'd7
    } reg_addr_e;

    typedef enum logic {
        EV_IDLE,
        EV_COMPARE
    } ev_state_e;

    typedef struct packed {
        logic [MIN_W-1:0]  mins;
        logic [HOUR_W-1:0] hours;
        logic [WDAY_W-1:0] wday;
    } tod_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
    parameter bit USE_DAYS = 1'b1,
    parameter int MIN_W    = 7,
    parameter int HOUR_W   = 6,
    parameter int DAY_N    = 7,
    parameter int WDAY_W   = 3
) (
    input  logic [MIN_W-1:0]  al_min,
    input  logic [HOUR_W-1:0] al_hour,
    input  logic [DAY_N-1:0]  al_days,
    input  logic [MIN_W-1:0]  t_min,
    input  logic [HOUR_W-1:0] t_hour,
    input  logic [WDAY_W-1:0] t_wday,
    output logic              hit
);
    localparam int DAY_SPAN = 1 << WDAY_W;

    logic time_ok;
    logic day_ok;

    assign time_ok = (al_min == t_min) && (al_hour == t_hour);

    generate
        if (USE_DAYS) begin : g_days
            logic [DAY_SPAN-1:0] days_ext;
            assign days_ext = DAY_SPAN'(al_days);
            assign day_ok   = days_ext[t_wday];
        end else begin : g_nodays
            logic unused_days;
            assign unused_days = ^{al_days, t_wday};
            assign day_ok      = 1'b1;
        end
    endgenerate

    assign hit = time_ok && day_ok;
endmodule

// File: rtl/alarm_eval_fsm.sv
module alarm_eval_fsm
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic minute_tick,
    input  tod_t cur_tod,
    input  logic wk_hit,
    input  logic dl_hit,
    input  logic wk_en,
    input  logic dl_en,
    output tod_t snap_tod,
    output logic wk_set,
    output logic dl_set
);
    ev_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (minute_tick) state_d = EV_COMPARE;
            EV_COMPARE: state_d = minute_tick ? EV_COMPARE : EV_IDLE;
            default:    state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= EV_IDLE;
            snap_tod <= '0;
        end else begin
            state_q <= state_d;
            if (minute_tick) snap_tod <= cur_tod;
        end
    end

    always_comb begin
        wk_set = 1'b0;
        dl_set = 1'b0;
        unique case (state_q)
            EV_IDLE: ;
            EV_COMPARE: begin
                wk_set = wk_hit && wk_en;
                dl_set = dl_hit && dl_en;
            end
            default: ;
        endcase
    end

    AST_COMPARE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_COMPARE) |-> $past(minute_tick)); // R4
    AST_SET_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_set && !minute_tick) |=> !wk_set); // R4
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wk_set,
    input  logic              dl_set,
    output logic [MIN_W-1:0]  wk_min,
    output logic [HOUR_W-1:0] wk_hour,
    output logic [DAY_N-1:0]  wk_days,
    output logic [MIN_W-1:0]  dl_min,
    output logic [HOUR_W-1:0] dl_hour,
    output logic              wk_en,
    output logic              dl_en,
    output logic              wk_flag,
    output logic              dl_flag
);
    reg_addr_e addr_e;
    logic      flag_wr;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign flag_wr = reg_wr && (addr_e == RA_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_min  <= '0;
            wk_hour <= '0;
            wk_days <= '0;
            dl_min  <= '0;
            dl_hour <= '0;
            wk_en   <= 1'b0;
            dl_en   <= 1'b0;
        end else if (reg_wr) begin
            unique case (addr_e)
                RA_WK_MIN:  wk_min  <= reg_wdata[MIN_W-1:0];
                RA_WK_HOUR: wk_hour <= reg_wdata[HOUR_W-1:0];
                RA_WK_DAYS: wk_days <= reg_wdata[DAY_N-1:0];
                RA_DL_MIN:  dl_min  <= reg_wdata[MIN_W-1:0];
                RA_DL_HOUR: dl_hour <= reg_wdata[HOUR_W-1:0];
                RA_ENABLE: begin
                    wk_en <= reg_wdata[0];
                    dl_en <= reg_wdata[1];
                end
                RA_STATUS: ;
                RA_NONE:   ;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_flag <= 1'b0;
            dl_flag <= 1'b0;
        end else begin
            if (wk_set)                        wk_flag <= 1'b1;
            else if (flag_wr && !reg_wdata[0]) wk_flag <= 1'b0;
            if (dl_set)                        dl_flag <= 1'b1;
            else if (flag_wr && !reg_wdata[1]) dl_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr_e)
            RA_WK_MIN:  reg_rdata = DATA_W'(wk_min);
            RA_WK_HOUR: reg_rdata = DATA_W'(wk_hour);
            RA_WK_DAYS: reg_rdata = DATA_W'(wk_days);
            RA_DL_MIN:  reg_rdata = DATA_W'(dl_min);
            RA_DL_HOUR: reg_rdata = DATA_W'(dl_hour);
            RA_ENABLE:  reg_rdata = DATA_W'({dl_en, wk_en});
            RA_STATUS:  reg_rdata = DATA_W'({dl_flag, wk_flag});
            RA_NONE:    reg_rdata = '0;
            default:    reg_rdata = '0;
        endcase
    end

    AST_WK_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wk_flag) |-> $past(wk_en)); // R6
    AST_DL_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_flag) |-> $past(dl_en)); // R6
    AST_WK_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wk_flag) |-> $past(reg_wr && reg_addr == 3'd6 && !reg_wdata[0])); // R7
    AST_DL_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dl_flag) |-> $past(reg_wr && reg_addr == 3'd6 && !reg_wdata[1])); // R7
endmodule

// File: rtl/alarm_pair_unit.sv
module alarm_pair_unit
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              minute_tick,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    logic [MIN_W-1:0]  wk_min, dl_min;
    logic [HOUR_W-1:0] wk_hour, dl_hour;
    logic [DAY_N-1:0]  wk_days;
    logic              wk_en, dl_en, wk_flag, dl_flag;
    logic              wk_set, dl_set, wk_hit, dl_hit;
    tod_t              cur_tod, snap_tod;

    assign cur_tod = '{mins: cur_min, hours: cur_hour, wday: cur_wday};

    alarm_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .wk_set(wk_set), .dl_set(dl_set),
        .wk_min(wk_min), .wk_hour(wk_hour), .wk_days(wk_days),
        .dl_min(dl_min), .dl_hour(dl_hour),
        .wk_en(wk_en), .dl_en(dl_en),
        .wk_flag(wk_flag), .dl_flag(dl_flag)
    );

    alarm_eval_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .minute_tick(minute_tick),
        .cur_tod(cur_tod), .wk_hit(wk_hit), .dl_hit(dl_hit),
        .wk_en(wk_en), .dl_en(dl_en),
        .snap_tod(snap_tod), .wk_set(wk_set), .dl_set(dl_set)
    );

    alarm_match #(.USE_DAYS(1'b1), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
                  .DAY_N(DAY_N), .WDAY_W(WDAY_W)) u_wk_cmp (
        .al_min(wk_min), .al_hour(wk_hour), .al_days(wk_days),
        .t_min(snap_tod.mins), .t_hour(snap_tod.hours), .t_wday(snap_tod.wday),
        .hit(wk_hit)
    );

    alarm_match #(.USE_DAYS(1'b0), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
                  .DAY_N(DAY_N), .WDAY_W(WDAY_W)) u_dl_cmp (
        .al_min(dl_min), .al_hour(dl_hour), .al_days({DAY_N{1'b0}}),
        .t_min(snap_tod.mins), .t_hour(snap_tod.hours), .t_wday(snap_tod.wday),
        .hit(dl_hit)
    );

    assign irq_n = ~((wk_flag & wk_en) | (dl_flag & dl_en));

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (wk_flag || dl_flag)); // R8
    AST_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wk_en) && !(dl_flag && dl_en)) |-> irq_n); // R8
endmodule

// File: tb/alarm_pair_unit_tb.sv
module alarm_pair_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       minute_tick = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [2:0] cur_wday = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alarm_pair_unit dut_i (
        .clk(clk), .rst_n(rst_n), .minute_tick(minute_tick),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    // behavioural reference model
    logic [6:0] m_wmin, m_dmin, s_min;
    logic [5:0] m_whr, m_dhr, s_hr;
    logic [7:0] m_wdays;
    logic [2:0] s_wd;
    logic m_wen, m_den, m_wf, m_df, m_pend;

    always @(posedge clk) begin
        bit ws, ds;
        if (!rst_n) begin
            m_wmin = 0; m_dmin = 0; m_whr = 0; m_dhr = 0; m_wdays = 0;
            m_wen = 0; m_den = 0; m_wf = 0; m_df = 0; m_pend = 0;
            s_min = 0; s_hr = 0; s_wd = 0;
        end else begin
            ws = m_pend && m_wen && s_min == m_wmin && s_hr == m_whr && m_wdays[s_wd];
            ds = m_pend && m_den && s_min == m_dmin && s_hr == m_dhr;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_wmin = reg_wdata[6:0];
                    3'd1: m_whr = reg_wdata[5:0];
                    3'd2: m_wdays = {1'b0, reg_wdata[6:0]};
                    3'd3: m_dmin = reg_wdata[6:0];
                    3'd4: m_dhr = reg_wdata[5:0];
                    3'd5: begin m_wen = reg_wdata[0]; m_den = reg_wdata[1]; end
                    3'd6: begin
                        if (!reg_wdata[0]) m_wf = 0;
                        if (!reg_wdata[1]) m_df = 0;
                    end
                    default: ;
                endcase
            end
            if (ws) m_wf = 1;
            if (ds) m_df = 1;
            m_pend = minute_tick;
            if (minute_tick) begin s_min = cur_min; s_hr = cur_hour; s_wd = cur_wday; end
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {1'b0, m_wmin};
            3'd1: return {2'b0, m_whr};
            3'd2: return m_wdays;
            3'd3: return {1'b0, m_dmin};
            3'd4: return {2'b0, m_dhr};
            3'd5: return {6'b0, m_den, m_wen};
            3'd6: return {6'b0, m_df, m_wf};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            chk({7'b0, irq_n}, {7'b0, ~((m_wf & m_wen) | (m_df & m_den))}, "R8 irq_n vs model");
            chk(reg_rdata, model_read(reg_addr), "R2 read data vs model");
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2 chk(reg_rdata, exp, tag);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        #1 chk({7'b0, irq_n}, {7'b0, exp}, tag);
    endtask

    task automatic tick_at(input logic [6:0] m, input logic [5:0] h, input logic [2:0] w);
        @(negedge clk);
        cur_min = m; cur_hour = h; cur_wday = w; minute_tick = 1;
        @(negedge clk);
        minute_tick = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        #2 chk({7'b0, irq_n}, 8'h01, "R1 irq_n in reset");
        rst_n = 1;
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R1 register reads zero after reset");

        // R2: register map, field widths
        wr_reg(3'd0, 8'hB0);
        rd_chk(3'd0, 8'h30, "R2 weekday minute keeps 7 bits");
        wr_reg(3'd1, 8'hC7);
        rd_chk(3'd1, 8'h07, "R2 weekday hour keeps 6 bits");
        wr_reg(3'd2, 8'h8A);
        rd_chk(3'd2, 8'h0A, "R2 mask keeps 7 bits");
        wr_reg(3'd7, 8'hFF);
        rd_chk(3'd7, 8'h00, "R2 address 7 reads zero");
        wr_reg(3'd5, 8'h01);
        rd_chk(3'd5, 8'h01, "R2 enable register");

        // R3: weekday alarm 07:30, Monday(1) and Wednesday(3)
        tick_at(7'h30, 6'h07, 3'd1);
        rd_chk(3'd6, 8'h01, "R3 weekday match on masked day sets flag");
        irq_chk(1'b0, "R8 irq asserted by enabled flag");
        wr_reg(3'd6, 8'hFF);
        rd_chk(3'd6, 8'h01, "R7 writing 1 keeps flag");
        wr_reg(3'd6, 8'h02);
        rd_chk(3'd6, 8'h00, "R7 writing 0 clears weekday flag");
        irq_chk(1'b1, "R8 irq released after clear");
        tick_at(7'h30, 6'h07, 3'd2);
        rd_chk(3'd6, 8'h00, "R3 unmasked weekday does not match");
        tick_at(7'h30, 6'h07, 3'd7);
        rd_chk(3'd6, 8'h00, "R3 weekday code 7 never matches");
        tick_at(7'h31, 6'h07, 3'd3);
        rd_chk(3'd6, 8'h00, "R3 minute mismatch");
        tick_at(7'h30, 6'h27, 3'd3);
        rd_chk(3'd6, 8'h00, "R3 hour bit 5 mismatch");
        tick_at(7'h30, 6'h07, 3'd3);
        rd_chk(3'd6, 8'h01, "R3 second masked weekday matches");
        wr_reg(3'd6, 8'h00);

        // R4: matching time without a strobe does nothing
        @(negedge clk);
        cur_min = 7'h30; cur_hour = 6'h07; cur_wday = 3'd1;
        repeat (4) @(negedge clk);
        rd_chk(3'd6, 8'h00, "R4 no strobe no flag");
        // R4: timing, flag not yet set one edge after strobe
        @(negedge clk);
        minute_tick = 1;
        @(negedge clk);
        minute_tick = 0;
        #2 chk(reg_rdata, 8'h00, "R4 flag not set one edge after strobe");
        @(negedge clk);
        #2 chk(reg_rdata, 8'h01, "R4 flag set at second edge");
        wr_reg(3'd6, 8'h00);

        // R5: daily alarm 12:45, ignores weekday; disabled first
        wr_reg(3'd3, 8'h45);
        wr_reg(3'd4, 8'h12);
        tick_at(7'h45, 6'h12, 3'd5);
        rd_chk(3'd6, 8'h00, "R6 disabled daily alarm does not set flag");
        wr_reg(3'd5, 8'h02);
        tick_at(7'h45, 6'h12, 3'd7);
        rd_chk(3'd6, 8'h02, "R5 daily alarm matches with any weekday code");
        irq_chk(1'b0, "R8 daily flag drives irq");

        // R8: clearing enable releases irq, flag kept (R6 sticky)
        wr_reg(3'd5, 8'h00);
        irq_chk(1'b1, "R8 enable clear releases irq");
        rd_chk(3'd6, 8'h02, "R6 flag stays set with enable off");
        wr_reg(3'd5, 8'h02);
        irq_chk(1'b0, "R8 re-enable restores irq");
        wr_reg(3'd6, 8'h01);
        rd_chk(3'd6, 8'h00, "R7 daily flag cleared by writing 0");

        // R7: set wins against same-edge clear
        wr_reg(3'd5, 8'h03);
        @(negedge clk);
        cur_min = 7'h30; cur_hour = 6'h07; cur_wday = 3'd1; minute_tick = 1;
        @(negedge clk);
        minute_tick = 0; reg_wr = 1; reg_addr = 3'd6; reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 0;
        #2 chk(reg_rdata, 8'h01, "R7 set wins over same-edge clear");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule